// File: doc/BRIEF.md
# Radio Byte Queues with Status Reporting

This block sits between a host command interface and a radio core. It holds one byte queue for each direction: the host fills the transmit queue and the radio drains it, while the radio fills the receive queue and the host drains it. Each queue holds 64 bytes. The queues let a packet larger than one burst move across in pieces. The host can poll to see how much room or data remains.

Alongside the queues the block builds a status byte, which the host interface returns with every command. The byte has three fields. The top bit is an active-low ready flag. The next three bits carry a main state code. The low four bits carry a saturating byte count. The count shows the bytes waiting in the receive queue or the free space in the transmit queue, and the top bit of the current command picks which. The radio supplies the state code from outside. It is replaced by a fault code when the receive queue has overflowed or the transmit queue has run dry during transmission. A fault code stays in place until the matching queue is flushed.

Top module: `radio_fifo_status`

## Requirements
- R1: After reset both queues are empty and both fault flags are low. With the command MSB at 0 the count field reads 15, and with the command MSB at 1 it reads 0.
- R2: Status bit 7 is 0 while `radio_ready` is high and 1 while it is low.
- R3: With no fault latched, status bits 6..4 equal `radio_state`. The codes are 000 idle, 001 receive, 010 transmit, 011 fast-transmit-ready, 100 calibrate and 101 settling.
- R4: Status bits 3..0 give the receive-queue fill level when `cmd_msb` is 1 and the transmit-queue free space when it is 0, capped at 15.
- R5: Each queue holds 64 bytes and returns them in arrival order. Read data appears on the clock edge that accepts the pop.
- R6: A radio push into a full receive queue discards the byte and sets `rx_overflow`. The status state field then reads 110.
- R7: A radio pop from an empty transmit queue sets `tx_underflow` only while `radio_state` is 010, and the state field then reads 111. An empty pop in any other state sets nothing.
- R8: A latched fault code replaces the external state code. The overflow code 110 wins over the underflow code 111.
- R9: Each fault flag stays set until its own queue is flushed. A flush empties that queue and clears only its own flag.
- R10: A host pop from an empty receive queue returns 0 and leaves the fill level unchanged.
- R11: A host push into a full transmit queue discards the byte and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_tx_push | input | 1 | Host writes a byte into the transmit queue |
| host_tx_data | input | 8 | Byte written by the host |
| host_rx_pop | input | 1 | Host reads a byte from the receive queue |
| host_rx_data | output | 8 | Byte read by the host, registered |
| radio_rx_push | input | 1 | Radio writes a received byte |
| radio_rx_data | input | 8 | Byte written by the radio |
| radio_tx_pop | input | 1 | Radio takes a byte to transmit |
| radio_tx_data | output | 8 | Byte taken by the radio, registered |
| radio_state | input | 3 | Main state code from the radio core |
| radio_ready | input | 1 | High when the radio core is ready |
| cmd_msb | input | 1 | MSB of the current command: 1 selects the receive fill level, 0 the transmit free space |
| rx_flush | input | 1 | Empty the receive queue and clear its fault |
| tx_flush | input | 1 | Empty the transmit queue and clear its fault |
| status_byte | output | 8 | Ready bit, state field and count field |
| rx_overflow | output | 1 | Receive-queue overflow latched |
| tx_underflow | output | 1 | Transmit-queue underflow latched |

## Verification
The hardest condition to reach is both fault flags latched at once, because the overflow code can only be seen winning over the underflow code when both are set. The stimulus first drains the transmit queue. It makes one more radio pop with the state set to transmit, which latches the underflow. It then fills the receive queue to all 64 entries and pushes one byte past it. A transmit-only flush follows. This shows that the overflow survives a flush of the other queue, and that the byte pushed past full never reaches the host.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'b000,
    ST_RX     = 3'b001,
    ST_TX     = 3'b010,
    ST_FTXRDY = 3'b011,
    ST_CAL    = 3'b100,
    ST_SETTLE = 3'b101,
    ST_RXOVF  = 3'b110,
    ST_TXUNF  = 3'b111
  } rstate_e;

  localparam int unsigned CNT_FIELD_W = 4;
  localparam int unsigned STATUS_W    = 8;

endpackage

// File: rtl/rfs_fifo.sv
module rfs_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count,
  output logic [CW-1:0] free_cnt,
  output logic          full,
  output logic          empty,
  output logic          push_rej,
  output logic          pop_dry
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;
  logic [DW-1:0] rd_data_q, rd_data_d;
  logic          do_push, do_pop;

  assign full     = (count_q == CW'(DEPTH));
  assign empty    = (count_q == '0);
  assign do_push  = push && !full && !flush;
  assign do_pop   = pop && !empty && !flush;
  assign push_rej = push && full && !flush;
  assign pop_dry  = pop && empty && !flush;

  always_comb begin
    wr_ptr_d  = wr_ptr_q;
    rd_ptr_d  = rd_ptr_q;
    count_d   = count_q;
    rd_data_d = rd_data_q;
    if (pop) begin
      rd_data_d = empty ? '0 : mem[rd_ptr_q];
    end
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (do_push) begin
        wr_ptr_d = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      end
      if (do_pop) begin
        rd_ptr_d = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      end
      case ({do_push, do_pop})
        2'b10:   count_d = count_q + 1'b1;
        2'b01:   count_d = count_q - 1'b1;
        default: count_d = count_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      count_q   <= '0;
      rd_data_q <= '0;
    end else begin
      wr_ptr_q  <= wr_ptr_d;
      rd_ptr_q  <= rd_ptr_d;
      count_q   <= count_d;
      rd_data_q <= rd_data_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wr_ptr_q] <= push_data;
    end
  end

  assign pop_data = rd_data_q;
  assign count    = count_q;
  assign free_cnt = CW'(DEPTH) - count_q;

endmodule

// File: rtl/rfs_status_gen.sv
module rfs_status_gen
  import rfs_pkg::*;
#(
  parameter int unsigned CW = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rdy,
  input  logic [2:0]          state_in,
  input  logic                cmd_msb,
  input  logic [CW-1:0]       rx_count,
  input  logic [CW-1:0]       tx_free,
  input  logic                rx_rej,
  input  logic                tx_dry,
  input  logic                rx_flush,
  input  logic                tx_flush,
  output logic [STATUS_W-1:0] status,
  output logic                ovf,
  output logic                unf
);

  logic                   ovf_q, ovf_d;
  logic                   unf_q, unf_d;
  logic [CW-1:0]          sel_cnt;
  logic [CNT_FIELD_W-1:0] cnt_field;
  logic [2:0]             state_field;

  always_comb begin
    ovf_d = ovf_q;
    unf_d = unf_q;
    if (rx_flush)    ovf_d = 1'b0;
    else if (rx_rej) ovf_d = 1'b1;
    if (tx_flush)    unf_d = 1'b0;
    else if (tx_dry && (state_in == ST_TX)) unf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign sel_cnt = cmd_msb ? rx_count : tx_free;

  generate
    if (CW > CNT_FIELD_W) begin : g_sat
      assign cnt_field = (sel_cnt > CW'({CNT_FIELD_W{1'b1}})) ?
                         {CNT_FIELD_W{1'b1}} : sel_cnt[CNT_FIELD_W-1:0];
    end else begin : g_ext
      assign cnt_field = CNT_FIELD_W'(sel_cnt);
    end
  endgenerate

  always_comb begin
    if (ovf_q)      state_field = ST_RXOVF;
    else if (unf_q) state_field = ST_TXUNF;
    else            state_field = state_in;
  end

  assign status = {~rdy, state_field, cnt_field};
  assign ovf    = ovf_q;
  assign unf    = unf_q;

endmodule

// File: rtl/radio_fifo_status.sv
module radio_fifo_status
  import rfs_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_tx_push,
  input  logic [DW-1:0] host_tx_data,
  input  logic          host_rx_pop,
  output logic [DW-1:0] host_rx_data,
  input  logic          radio_rx_push,
  input  logic [DW-1:0] radio_rx_data,
  input  logic          radio_tx_pop,
  output logic [DW-1:0] radio_tx_data,
  input  logic [2:0]    radio_state,
  input  logic          radio_ready,
  input  logic          cmd_msb,
  input  logic          rx_flush,
  input  logic          tx_flush,
  output logic [7:0]    status_byte,
  output logic          rx_overflow,
  output logic          tx_underflow
);

  logic [CW-1:0] rx_cnt, rx_free, tx_cnt, tx_free;
  logic          rx_full, rx_empty, tx_full, tx_empty;
  logic          rx_rej, rx_dry, tx_rej, tx_dry;

  rfs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (rx_flush),
    .push     (radio_rx_push),
    .push_data(radio_rx_data),
    .pop      (host_rx_pop),
    .pop_data (host_rx_data),
    .count    (rx_cnt),
    .free_cnt (rx_free),
    .full     (rx_full),
    .empty    (rx_empty),
    .push_rej (rx_rej),
    .pop_dry  (rx_dry)
  );

  rfs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (tx_flush),
    .push     (host_tx_push),
    .push_data(host_tx_data),
    .pop      (radio_tx_pop),
    .pop_data (radio_tx_data),
    .count    (tx_cnt),
    .free_cnt (tx_free),
    .full     (tx_full),
    .empty    (tx_empty),
    .push_rej (tx_rej),
    .pop_dry  (tx_dry)
  );

  rfs_status_gen #(.CW(CW)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdy      (radio_ready),
    .state_in (radio_state),
    .cmd_msb  (cmd_msb),
    .rx_count (rx_cnt),
    .tx_free  (tx_free),
    .rx_rej   (rx_rej),
    .tx_dry   (tx_dry),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush),
    .status   (status_byte),
    .ovf      (rx_overflow),
    .unf      (tx_underflow)
  );

  logic unused_ok;
  assign unused_ok = ^{rx_free, tx_cnt, rx_dry, tx_rej, tx_full};

endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_rx_pop,
  input logic [7:0]    host_rx_data,
  input logic          radio_rx_push,
  input logic          radio_tx_pop,
  input logic [2:0]    radio_state,
  input logic          rx_flush,
  input logic          tx_flush,
  input logic [7:0]    status_byte,
  input logic          rx_overflow,
  input logic          tx_underflow,
  input logic [CW-1:0] rx_cnt,
  input logic          rx_full,
  input logic          rx_empty,
  input logic          tx_empty
);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH)); // R5

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    radio_rx_push && rx_full && !rx_flush |=> rx_overflow && $stable(rx_cnt)); // R6

  AST_UNF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    radio_tx_pop && tx_empty && (radio_state == 3'b010) && !tx_flush |=> tx_underflow); // R7

  AST_OVF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |-> status_byte[6:4] == 3'b110); // R8

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow && !rx_flush |=> rx_overflow); // R9

  AST_UNF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underflow && !tx_flush |=> tx_underflow); // R9

  AST_FLUSH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> !rx_overflow && (rx_cnt == '0)); // R9

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    host_rx_pop && rx_empty && !rx_flush && !radio_rx_push |=> host_rx_data == 8'h00 && $stable(rx_cnt)); // R10

endmodule

bind radio_fifo_status rfs_checker #(.DEPTH(DEPTH)) u_rfs_chk (.*);

// File: tb/test_radio_fifo_status.sv
`timescale 1ns/1ps
module test_radio_fifo_status;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_tx_push = 1'b0;
  logic [7:0] host_tx_data = '0;
  logic       host_rx_pop = 1'b0;
  logic [7:0] host_rx_data;
  logic       radio_rx_push = 1'b0;
  logic [7:0] radio_rx_data = '0;
  logic       radio_tx_pop = 1'b0;
  logic [7:0] radio_tx_data;
  logic [2:0] radio_state = 3'b000;
  logic       radio_ready = 1'b1;
  logic       cmd_msb = 1'b0;
  logic       rx_flush = 1'b0;
  logic       tx_flush = 1'b0;
  logic [7:0] status_byte;
  logic       rx_overflow;
  logic       tx_underflow;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  radio_fifo_status i_radio_fifo_status (.*);

  // {ready, state, cmd_msb, expected status} with both queues empty
  localparam logic [12:0] VEC [8] = '{
    {1'b1, 3'd0, 1'b0, 8'h0F},
    {1'b0, 3'd1, 1'b1, 8'h90},
    {1'b1, 3'd2, 1'b0, 8'h2F},
    {1'b1, 3'd3, 1'b1, 8'h30},
    {1'b0, 3'd4, 1'b0, 8'hCF},
    {1'b1, 3'd5, 1'b1, 8'h50},
    {1'b1, 3'd6, 1'b0, 8'h6F},
    {1'b1, 3'd7, 1'b1, 8'h70}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rpush(input logic [7:0] d);
    radio_rx_push = 1'b1; radio_rx_data = d; step(); radio_rx_push = 1'b0;
  endtask

  task automatic hpush(input logic [7:0] d);
    host_tx_push = 1'b1; host_tx_data = d; step(); host_tx_push = 1'b0;
  endtask

  task automatic hpop();
    host_rx_pop = 1'b1; step(); host_rx_pop = 1'b0;
  endtask

  task automatic rpop();
    radio_tx_pop = 1'b1; step(); radio_tx_pop = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    #23;
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 status msb0", status_byte, 8'h0F);
    chk("R1 flags", {6'd0, rx_overflow, tx_underflow}, 8'h00);
    cmd_msb = 1'b1; #1;
    chk("R1 status msb1", status_byte, 8'h00);

    // R2 R3 table walk
    for (int i = 0; i < 8; i++) begin
      {radio_ready, radio_state, cmd_msb} = VEC[i][12:8];
      #1;
      chk("R2/R3 vector", status_byte, VEC[i][7:0]);
    end

    // R4 receive fill level and saturation
    radio_ready = 1'b1; radio_state = 3'd1; cmd_msb = 1'b1;
    for (int i = 0; i < 3; i++) rpush(8'hA0 + 8'(i));
    chk("R4 rx count 3", status_byte, 8'h13);
    for (int i = 3; i < 20; i++) rpush(8'hA0 + 8'(i));
    chk("R4 rx count sat", status_byte, 8'h1F);
    for (int i = 0; i < 20; i++) begin
      hpop();
      chk("R5 rx order", host_rx_data, 8'hA0 + 8'(i));
    end
    chk("R4 rx drained", status_byte, 8'h10);

    // R10 empty host pop
    hpop();
    chk("R10 empty pop data", host_rx_data, 8'h00);
    chk("R10 count unchanged", status_byte, 8'h10);

    // R4 R11 transmit free space
    radio_state = 3'd0; cmd_msb = 1'b0;
    for (int i = 0; i < 50; i++) hpush(8'(i));
    chk("R4 tx free 14", status_byte, 8'h0E);
    for (int i = 50; i < 64; i++) hpush(8'(i));
    chk("R4 tx free 0", status_byte, 8'h00);
    hpush(8'hEE);
    chk("R11 push full dropped", status_byte, 8'h00);
    chk("R11 no flag", {7'd0, tx_underflow}, 8'h00);
    for (int i = 0; i < 64; i++) begin
      rpop();
      chk("R5 tx order", radio_tx_data, 8'(i));
    end
    chk("R4 tx free sat", status_byte, 8'h0F);

    // R7 underflow only in transmit state
    radio_state = 3'd1;
    rpop();
    chk("R7 no flag outside tx", {7'd0, tx_underflow}, 8'h00);
    chk("R7 dropped byte absent", radio_tx_data, 8'h00);
    radio_state = 3'd2;
    rpop();
    chk("R7 underflow flag", {7'd0, tx_underflow}, 8'h01);
    chk("R7 underflow code", status_byte, 8'h7F);

    // R6 R8 overflow beats underflow
    cmd_msb = 1'b1;
    for (int i = 0; i < 64; i++) rpush(8'(i));
    chk("R8 underflow code with full rx", status_byte, 8'h7F);
    rpush(8'h55);
    chk("R6 overflow flag", {7'd0, rx_overflow}, 8'h01);
    chk("R8 overflow priority", status_byte, 8'h6F);

    // R9 tx flush clears only underflow
    tx_flush = 1'b1; step(); tx_flush = 1'b0;
    chk("R9 tx flush clears unf", {6'd0, rx_overflow, tx_underflow}, 8'h02);
    for (int i = 0; i < 64; i++) begin
      hpop();
      chk("R6 rx kept bytes", host_rx_data, 8'(i));
    end
    hpop();
    chk("R6 overflow byte dropped", host_rx_data, 8'h00);
    chk("R9 overflow held", status_byte, 8'h60);
    rx_flush = 1'b1; step(); rx_flush = 1'b0;
    chk("R9 rx flush clears ovf", {7'd0, rx_overflow}, 8'h00);
    chk("R3 state restored", status_byte, 8'h20);

    // R9 flush empties queue
    for (int i = 0; i < 5; i++) rpush(8'h10);
    chk("R4 rx count 5", status_byte, 8'h25);
    rx_flush = 1'b1; step(); rx_flush = 1'b0;
    chk("R9 flush empties", status_byte, 8'h20);

    finish_run();
  end

endmodule